// File: doc/BRIEF.md
# Buffered PWM Compare Unit

This block is the compare stage of a PWM generator. Software writes a 16-bit compare value into a shadow register. The unit copies that value into an active register only when the PWM counter passes through zero. Each cycle it compares the running counter against the active value. When they are equal, and the active value does not exceed the counter's load value, it raises a one-cycle match pulse for the output-action and interrupt logic downstream.

Two commit policies are available, chosen by a mode pin.

- **Immediate mode:** a pending value takes effect at the next counter-zero strobe.
- **Synchronous mode:** a pending value waits for a global update request first, and then takes effect at the first counter-zero strobe after that request.

A value that is rewritten before it commits is lost.

The write port is a plain register write strobe and has no back-pressure: every write is accepted in the cycle it is presented. The counter, load and mode inputs are sampled every cycle.

Top module: `pwm_cmp_stage`

## Requirements
- R1: After reset, `rd_data` reads 0, `match` is low, and the active compare value is 0. A counter value of 0 with the load value at 0 or higher therefore produces a match.
- R2: A write stores `wr_data[15:0]` as the shadow value. `rd_data[15:0]` shows it from the cycle after the write. `rd_data[31:16]` always reads 0, whatever was written to those bits.
- R3: `match` is high in the cycle after one in which `cnt` equals the active value and the active value is less than or equal to `load_val`. Otherwise it is low.
- R4: While the active value is greater than `load_val`, `match` stays low for every counter value.
- R5: With `sync_mode` = 0, a pending value becomes active at the clock edge that samples `cnt_zero` high. Until then, the old active value is used.
- R6: With `sync_mode` = 1, a counter-zero strobe commits a pending value only if a `sync_req` pulse has been seen since the value became pending. Without such a pulse, the strobe leaves the active value unchanged.
- R7: A second write before the commit replaces the pending value. The first value never becomes active.
- R8: A `sync_req` pulse seen while nothing is pending is dropped. A value written later still needs a new request before it can commit.
- R9: `rd_data` returns the shadow value, even while a different, older value is still active.
- R10: In the cycle a commit happens, the comparison still uses the value that was active before that commit.
- R11: A write in the same cycle as a commit does not affect that commit. The commit installs the previous shadow value, and the new value stays pending for the next eligible zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; only bits 15:0 are kept |
| rd_data | output | 32 | Shadow value, zero-extended |
| cnt | input | 16 | Running PWM counter value |
| cnt_zero | input | 1 | Counter-zero strobe |
| load_val | input | 16 | Counter load (period) value |
| sync_mode | input | 1 | 0 = commit at next zero, 1 = commit at zero after a request |
| sync_req | input | 1 | Global synchronous-update request pulse |
| match | output | 1 | One-cycle compare match pulse |

## Verification
Both results are due one clock edge after the inputs that cause them:

- `rd_data` reflects a write after the edge that samples `wr_en`.
- `match` reflects the comparison of `cnt` against the active value as it stood before that same edge.

A commit at an edge therefore first shows in the match result of the following row. The bench drives each vector on a falling edge and checks both outputs on the next falling edge. Each table row's expected values describe exactly the edge that row's inputs produce. The active value is never read directly: it is inferred from which counter values produce a match.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int CMP_W_DEF = 16;
  localparam int REG_W_DEF = 32;

  typedef enum logic {
    UPD_NEXT_ZERO = 1'b0,
    UPD_ON_REQUEST = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/cmp_shadow.sv
module cmp_shadow #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          cnt_zero,
  input  logic          sync_mode,
  input  logic          sync_req,
  output logic [CW-1:0] shadow_q,
  output logic          pend_q,
  output logic          arm_q,
  output logic          commit
);
  import pwm_cmp_pkg::*;

  upd_mode_e mode;
  logic      gate_ok;

  assign mode    = upd_mode_e'(sync_mode);
  assign gate_ok = (mode == UPD_NEXT_ZERO) || arm_q;
  assign commit  = cnt_zero && pend_q && gate_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
      arm_q    <= 1'b0;
    end else begin
      if (wr_en) shadow_q <= wr_val;

      if (wr_en)       pend_q <= 1'b1;
      else if (commit) pend_q <= 1'b0;

      if (commit)                         arm_q <= 1'b0;
      else if (sync_req && (pend_q || wr_en)) arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cmp_active.sv
module cmp_active #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [CW-1:0] shadow,
  output logic [CW-1:0] act_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      act_q <= '0;
    else if (commit) act_q <= shadow;
  end
endmodule

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] act,
  input  logic [CW-1:0] load_val,
  output logic          match_q
);
  logic in_range;
  logic equal;

  assign in_range = (act <= load_val);
  assign equal    = (cnt == act);

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= equal && in_range;
  end
endmodule

// File: rtl/pwm_cmp_stage.sv
module pwm_cmp_stage #(
  parameter int CMP_W = pwm_cmp_pkg::CMP_W_DEF,
  parameter int REG_W = pwm_cmp_pkg::REG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [CMP_W-1:0] cnt,
  input  logic             cnt_zero,
  input  logic [CMP_W-1:0] load_val,
  input  logic             sync_mode,
  input  logic             sync_req,
  output logic             match
);
  localparam int PAD_W = REG_W - CMP_W;

  logic [CMP_W-1:0] shadow_q;
  logic [CMP_W-1:0] act_q;
  logic             pend_q;
  logic             arm_q;
  logic             commit;

  cmp_shadow #(.CW(CMP_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_val    (wr_data[CMP_W-1:0]),
    .cnt_zero  (cnt_zero),
    .sync_mode (sync_mode),
    .sync_req  (sync_req),
    .shadow_q  (shadow_q),
    .pend_q    (pend_q),
    .arm_q     (arm_q),
    .commit    (commit)
  );

  cmp_active #(.CW(CMP_W)) u_active (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .shadow (shadow_q),
    .act_q  (act_q)
  );

  cmp_match #(.CW(CMP_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .act      (act_q),
    .load_val (load_val),
    .match_q  (match)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, shadow_q};
    end else begin : g_nopad
      assign rd_data = shadow_q[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pwm_cmp_chk.sv
module pwm_cmp_chk #(
  parameter int CMP_W = 16,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic [CMP_W-1:0] cnt,
  input logic             cnt_zero,
  input logic [CMP_W-1:0] load_val,
  input logic             sync_mode,
  input logic [CMP_W-1:0] act_q,
  input logic             pend_q,
  input logic             arm_q,
  input logic             match
);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:CMP_W] == '0);

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[CMP_W-1:0] == $past(wr_data[CMP_W-1:0]));

  assert_match_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> ($past(cnt) == $past(act_q)));

  assert_out_of_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q > load_val) |=> !match);

  assert_hold_off_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_zero |=> act_q == $past(act_q));

  assert_sync_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && sync_mode && !arm_q) |=> act_q == $past(act_q));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> act_q == $past(act_q));
endmodule

bind pwm_cmp_stage pwm_cmp_chk #(.CMP_W(CMP_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .cnt       (cnt),
  .cnt_zero  (cnt_zero),
  .load_val  (load_val),
  .sync_mode (sync_mode),
  .act_q     (act_q),
  .pend_q    (pend_q),
  .arm_q     (arm_q),
  .match     (match)
);

// File: tb/sim_pwm_cmp_stage.sv
module sim_pwm_cmp_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 35;

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic [15:0] cnt;
    logic        z;
    logic        sm;
    logic        sr;
    logic [15:0] ld;
    logic        em;
    logic [15:0] erd;
    logic [3:0]  rq;
  } vec_t;

  function automatic vec_t mk(input logic wr, input logic [31:0] wd,
                              input logic [15:0] c, input logic z,
                              input logic sm, input logic sr,
                              input logic [15:0] ld, input logic em,
                              input logic [15:0] erd, input logic [3:0] rq);
    vec_t v;
    v.wr = wr; v.wd = wd; v.cnt = c; v.z = z; v.sm = sm; v.sr = sr;
    v.ld = ld; v.em = em; v.erd = erd; v.rq = rq;
    return v;
  endfunction

  localparam vec_t VEC [NV] = '{
    mk(0, 32'h0,        16'd5,   0, 0, 0, 16'd100, 0, 16'h0,  4'd1),  // R1 idle
    mk(0, 32'h0,        16'd0,   1, 0, 0, 16'd100, 1, 16'h0,  4'd1),  // R1 active 0 matches
    mk(1, 32'hABCD0032, 16'd50,  0, 0, 0, 16'd100, 0, 16'h32, 4'd2),  // R2 write 50
    mk(0, 32'h0,        16'd50,  0, 0, 0, 16'd100, 0, 16'h32, 4'd5),  // R5 not yet active
    mk(0, 32'h0,        16'd0,   1, 0, 0, 16'd100, 1, 16'h32, 4'd10), // R10 old value compared
    mk(0, 32'h0,        16'd50,  0, 0, 0, 16'd100, 1, 16'h32, 4'd5),  // R5 now active
    mk(0, 32'h0,        16'd51,  0, 0, 0, 16'd100, 0, 16'h32, 4'd3),  // R3 no equality
    mk(1, 32'd200,      16'd1,   0, 0, 0, 16'd100, 0, 16'd200, 4'd2),
    mk(0, 32'h0,        16'd0,   1, 0, 0, 16'd100, 0, 16'd200, 4'd5),
    mk(0, 32'h0,        16'd100, 0, 0, 0, 16'd100, 0, 16'd200, 4'd4), // R4
    mk(0, 32'h0,        16'd200, 0, 0, 0, 16'd100, 0, 16'd200, 4'd4), // R4 above load
    mk(0, 32'h0,        16'd200, 0, 0, 0, 16'd255, 1, 16'd200, 4'd3), // R3 in range
    mk(1, 32'd70,       16'd1,   0, 1, 0, 16'd255, 0, 16'd70,  4'd6),
    mk(0, 32'h0,        16'd0,   1, 1, 0, 16'd255, 0, 16'd70,  4'd6), // R6 zero, no request
    mk(0, 32'h0,        16'd70,  0, 1, 0, 16'd255, 0, 16'd70,  4'd6),
    mk(0, 32'h0,        16'd200, 0, 1, 0, 16'd255, 1, 16'd70,  4'd9), // R9 old active, new readback
    mk(0, 32'h0,        16'd3,   0, 1, 1, 16'd255, 0, 16'd70,  4'd6),
    mk(0, 32'h0,        16'd0,   1, 1, 0, 16'd255, 0, 16'd70,  4'd6),
    mk(0, 32'h0,        16'd70,  0, 1, 0, 16'd255, 1, 16'd70,  4'd6), // R6 committed
    mk(1, 32'd10,       16'd3,   0, 1, 0, 16'd255, 0, 16'd10,  4'd7),
    mk(1, 32'd20,       16'd3,   0, 1, 0, 16'd255, 0, 16'd20,  4'd7),
    mk(0, 32'h0,        16'd3,   0, 1, 1, 16'd255, 0, 16'd20,  4'd7),
    mk(0, 32'h0,        16'd0,   1, 1, 0, 16'd255, 0, 16'd20,  4'd7),
    mk(0, 32'h0,        16'd10,  0, 1, 0, 16'd255, 0, 16'd20,  4'd7), // R7 lost value
    mk(0, 32'h0,        16'd20,  0, 1, 0, 16'd255, 1, 16'd20,  4'd7),
    mk(0, 32'h0,        16'd5,   0, 1, 1, 16'd255, 0, 16'd20,  4'd8), // R8 idle request
    mk(0, 32'h0,        16'd0,   1, 1, 0, 16'd255, 0, 16'd20,  4'd8),
    mk(1, 32'd30,       16'd5,   0, 1, 0, 16'd255, 0, 16'd30,  4'd8),
    mk(0, 32'h0,        16'd0,   1, 1, 0, 16'd255, 0, 16'd30,  4'd8),
    mk(0, 32'h0,        16'd30,  0, 1, 0, 16'd255, 0, 16'd30,  4'd8), // R8 not committed
    mk(0, 32'h0,        16'd20,  0, 1, 0, 16'd255, 1, 16'd30,  4'd8),
    mk(1, 32'd40,       16'd0,   1, 0, 0, 16'd255, 0, 16'd40,  4'd11), // R11 write at commit
    mk(0, 32'h0,        16'd30,  0, 0, 0, 16'd255, 1, 16'd40,  4'd11),
    mk(0, 32'h0,        16'd0,   1, 0, 0, 16'd255, 0, 16'd40,  4'd11),
    mk(0, 32'h0,        16'd40,  0, 0, 0, 16'd255, 1, 16'd40,  4'd11)
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [15:0] cnt;
  logic        cnt_zero;
  logic [15:0] load_val;
  logic        sync_mode;
  logic        sync_req;
  logic        match;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cmp_stage u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .cnt       (cnt),
    .cnt_zero  (cnt_zero),
    .load_val  (load_val),
    .sync_mode (sync_mode),
    .sync_req  (sync_req),
    .match     (match)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [31:0] d, input logic [15:0] c,
                       input logic z, input logic sm, input logic sr, input logic [15:0] l);
    wr_en = w; wr_data = d; cnt = c; cnt_zero = z;
    sync_mode = sm; sync_req = sr; load_val = l;
  endtask

  initial begin
    drive(0, 32'h0, 16'd7, 0, 0, 0, 16'd100);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset rd_data", rd_data, 32'h0);
    chk("R1 reset match", {31'b0, match}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].wd, VEC[i].cnt, VEC[i].z, VEC[i].sm, VEC[i].sr, VEC[i].ld);
      @(negedge clk);
      chk($sformatf("R%0d row %0d match", VEC[i].rq, i), {31'b0, match}, {31'b0, VEC[i].em});
      chk($sformatf("R%0d row %0d rd_data", VEC[i].rq, i), rd_data, {16'h0, VEC[i].erd});
    end

    // R2: upper write bits are discarded
    drive(1, 32'hFFFF_FFFF, 16'd9, 0, 0, 0, 16'd255);
    @(negedge clk);
    chk("R2 upper bits read zero", rd_data, 32'h0000_FFFF);

    // R1: reset mid-run returns everything to zero, pending write dropped
    drive(0, 32'h0, 16'd9, 0, 0, 0, 16'd255);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rd_data after reset", rd_data, 32'h0);
    drive(0, 32'h0, 16'd0, 1, 0, 0, 16'd0);
    @(negedge clk);
    chk("R1 active zero matches at load 0", {31'b0, match}, 32'h1);
    drive(0, 32'h0, 16'hFFFF, 0, 0, 0, 16'hFFFF);
    @(negedge clk);
    chk("R1 no stale value after reset", {31'b0, match}, 32'h0);
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 5000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule